// File: doc/BRIEF.md
# Dual-Channel Interleaved Converter Bus Receiver

This block sits next to a dual-channel 10-bit converter whose I and Q results share one output bus. It captures the bus on both edges of the converter clock: the rising-edge register takes I, and the falling-edge register takes Q. It then joins each I word with the Q word of the same sampling instant and presents them together as one aligned pair with a one-cycle valid strobe. Q reaches the bus half a cycle later than I, so the pairing takes the I word from one rising edge and the Q word from the falling edge that follows it.

A static mode input selects interleaved, I-only or Q-only reception. The block drives the converter's channel-select line to match the mode. It also drives the active-high bus-release line, taken from a hold request. Words captured while the bus is released are never emitted. After reset, after any mode change and after the bus is taken back, the valid strobe stays low until the converter's pipeline has flushed. Each emitted pair carries a small wrapping tag, so a consumer can follow the sample order.

Top module: `adc_iq_capture`

## Requirements
- R1: In interleaved mode (mode code 2'b00, and also 2'b11), the pair presented after rising edge e holds in bits [9:0] of `pair_i_o` the bus word taken at rising edge e-1. It holds in `pair_q_o` the bus word taken at the falling edge between e-1 and e. For a converter with I latency 7 and Q latency 7.5 cycles, both words belong to the sample taken at edge e-8.
- R2: In I-only mode (code 2'b01), each emitted pair carries the bus word taken at the preceding rising edge in `pair_i_o`, and `pair_q_o` is zero.
- R3: In Q-only mode (code 2'b10), each emitted pair carries the bus word taken at the preceding falling edge in `pair_q_o`, and `pair_i_o` is zero.
- R4: After the last rising edge at which reset is high, `pair_valid_o` stays low for 8 rising edges. It can first rise at the 9th edge.
- R5: A rising edge at which `mode_i` differs from its value at the previous edge keeps `pair_valid_o` low at that edge and at the 8 edges that follow.
- R6: `adc_oen_o` takes the value of `hold_bus_i` one rising edge later. Every edge at which `adc_oen_o` is high keeps `pair_valid_o` low at that edge and at the 8 edges that follow, so words captured from a released bus are discarded.
- R7: `adc_sel_o` is held high in I-only mode and low in Q-only mode. In interleaved mode it follows the clock: high during the high phase and low during the low phase.
- R8: `pair_tag_o` is 0 on the first pair after reset and increases by one (wrapping at 2^3) with each emitted pair. It changes only when a pair is emitted.
- R9: While reset is held, `pair_valid_o`, `pair_i_o`, `pair_q_o`, `pair_tag_o` and `adc_oen_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock, both edges used |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Reception mode: 00/11 interleaved, 01 I-only, 10 Q-only |
| hold_bus_i | input | 1 | Request to release the converter bus |
| adc_data_i | input | 10 | Shared converter output bus, bit 0 LSB |
| adc_oen_o | output | 1 | Converter output release, high means bus released |
| adc_sel_o | output | 1 | Converter channel select, high picks I |
| pair_valid_o | output | 1 | One-cycle strobe for an emitted pair |
| pair_i_o | output | 10 | I word of the emitted pair |
| pair_q_o | output | 10 | Q word of the emitted pair |
| pair_tag_o | output | 3 | Wrapping order tag of the emitted pair |

## Verification
The bench models the converter as two arithmetic streams that have different slopes, so an I/Q swap or a one-sample slip gives a wrong value. It drives I for sample n so that I is stable at rising edge n+7, and Q so that Q is stable at the falling edge n+7.5. It runs all four mode codes and checks every edge of each. The interleaved runs separate correct pairing from pairing with the wrong falling edge. The single-channel runs check that the unused half is zeroed and that the correct edge is used. A mid-run bus release (with junk data placed on the bus), mode switches and a reset in mid-run test the flush window edge by edge. The same run also checks tag continuity and the select level on both clock phases.

// File: rtl/adcrx_pkg.sv
`timescale 1ns/1ps
package adcrx_pkg;

    localparam int BUS_W = 10;

    typedef enum logic [1:0] {
        RX_IQ     = 2'b00,
        RX_I_ONLY = 2'b01,
        RX_Q_ONLY = 2'b10,
        RX_IQ_ALT = 2'b11
    } rx_mode_e;

    typedef struct packed {
        logic [BUS_W-1:0] i_word;
        logic [BUS_W-1:0] q_word;
    } iq_pair_t;

    function automatic logic uses_both_edges(rx_mode_e m);
        return (m != RX_I_ONLY) && (m != RX_Q_ONLY);
    endfunction

endpackage

// File: rtl/adcrx_edge_capture.sv
`timescale 1ns/1ps
module adcrx_edge_capture
    import adcrx_pkg::*;
(
    input  logic             clk,
    input  logic [BUS_W-1:0] bus_i,
    output logic [BUS_W-1:0] rise_word_o,
    output logic [BUS_W-1:0] fall_word_o
);

    // I word is stable at the rising edge.
    always_ff @(posedge clk) begin
        rise_word_o <= bus_i;
    end

    // Q word is stable half a cycle later, at the falling edge.
    always_ff @(negedge clk) begin
        fall_word_o <= bus_i;
    end

endmodule

// File: rtl/adcrx_flush_gate.sv
`timescale 1ns/1ps
module adcrx_flush_gate #(
    parameter int FLUSH_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    output logic open_o
);

    localparam int CNT_W = $clog2(FLUSH_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(FLUSH_CYCLES);

    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            remain_q <= LOAD;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign open_o = (remain_q == '0) && !restart_i && !rst;

endmodule

// File: rtl/adcrx_pair_align.sv
`timescale 1ns/1ps
module adcrx_pair_align
    import adcrx_pkg::*;
#(
    parameter int TAG_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             emit_i,
    input  rx_mode_e         mode_i,
    input  logic [BUS_W-1:0] rise_word_i,
    input  logic [BUS_W-1:0] fall_word_i,
    output logic             valid_o,
    output iq_pair_t         pair_o,
    output logic [TAG_W-1:0] tag_o
);

    logic [TAG_W-1:0] next_tag_q;
    iq_pair_t         shaped;

    always_comb begin
        shaped = '0;
        if (uses_both_edges(mode_i)) begin
            shaped.i_word = rise_word_i;
            shaped.q_word = fall_word_i;
        end else if (mode_i == RX_I_ONLY) begin
            shaped.i_word = rise_word_i;
        end else begin
            shaped.q_word = fall_word_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o    <= 1'b0;
            pair_o     <= '0;
            tag_o      <= '0;
            next_tag_q <= '0;
        end else begin
            valid_o <= emit_i;
            if (emit_i) begin
                pair_o     <= shaped;
                tag_o      <= next_tag_q;
                next_tag_q <= next_tag_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/adc_iq_capture.sv
`timescale 1ns/1ps
module adc_iq_capture
    import adcrx_pkg::*;
#(
    parameter int TAG_W        = 3,
    parameter int FLUSH_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_i,
    input  logic             hold_bus_i,
    input  logic [9:0]       adc_data_i,
    output logic             adc_oen_o,
    output logic             adc_sel_o,
    output logic             pair_valid_o,
    output logic [9:0]       pair_i_o,
    output logic [9:0]       pair_q_o,
    output logic [TAG_W-1:0] pair_tag_o
);

    rx_mode_e         mode_q;
    logic             mode_moved;
    logic             gate_open;
    logic [BUS_W-1:0] rise_word;
    logic [BUS_W-1:0] fall_word;
    iq_pair_t         pair;

    assign mode_moved = (rx_mode_e'(mode_i) != mode_q);

    always_ff @(posedge clk) begin
        mode_q <= rx_mode_e'(mode_i);
        if (rst) begin
            adc_oen_o <= 1'b0;
        end else begin
            adc_oen_o <= hold_bus_i;
        end
    end

    always_comb begin
        unique case (mode_q)
            RX_I_ONLY: adc_sel_o = 1'b1;
            RX_Q_ONLY: adc_sel_o = 1'b0;
            default:   adc_sel_o = clk;
        endcase
    end

    adcrx_edge_capture u_cap (
        .clk         (clk),
        .bus_i       (adc_data_i),
        .rise_word_o (rise_word),
        .fall_word_o (fall_word)
    );

    adcrx_flush_gate #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .restart_i (mode_moved || adc_oen_o),
        .open_o    (gate_open)
    );

    adcrx_pair_align #(.TAG_W(TAG_W)) u_align (
        .clk         (clk),
        .rst         (rst),
        .emit_i      (gate_open),
        .mode_i      (mode_q),
        .rise_word_i (rise_word),
        .fall_word_i (fall_word),
        .valid_o     (pair_valid_o),
        .pair_o      (pair),
        .tag_o       (pair_tag_o)
    );

    assign pair_i_o = pair.i_word;
    assign pair_q_o = pair.q_word;

endmodule

// File: rtl/adc_iq_capture_chk.sv
`timescale 1ns/1ps
module adc_iq_capture_chk #(
    parameter int TAG_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mode_i,
    input logic             adc_oen_o,
    input logic             adc_sel_o,
    input logic             pair_valid_o,
    input logic [9:0]       pair_i_o,
    input logic [9:0]       pair_q_o,
    input logic [TAG_W-1:0] pair_tag_o
);

    // R4 / R9: reset leaves no pair behind
    a_r4_reset_quiet: assert property (@(posedge clk)
        rst |=> (!pair_valid_o && pair_tag_o == '0 && !adc_oen_o));

    // R5: a mode change blocks the next strobe
    a_r5_mode_flush: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_i) |=> !pair_valid_o);

    // R6: released bus never yields a pair
    a_r6_release_drop: assert property (@(posedge clk) disable iff (rst)
        adc_oen_o |=> !pair_valid_o);

    // R2: I-only pairs carry a zero Q half
    a_r2_q_zeroed: assert property (@(posedge clk) disable iff (rst)
        (pair_valid_o && $past(mode_i) == 2'b01 && $past(mode_i, 2) == 2'b01)
            |-> pair_q_o == '0);

    // R3: Q-only pairs carry a zero I half
    a_r3_i_zeroed: assert property (@(posedge clk) disable iff (rst)
        (pair_valid_o && $past(mode_i) == 2'b10 && $past(mode_i, 2) == 2'b10)
            |-> pair_i_o == '0);

    // R8: tag moves only with an emitted pair
    a_r8_tag_on_emit: assert property (@(posedge clk) disable iff (rst)
        !$stable(pair_tag_o) |-> pair_valid_o);

    // R7: I-only holds select high
    a_r7_sel_i_high: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_i) == 2'b01) |-> adc_sel_o);

endmodule

bind adc_iq_capture adc_iq_capture_chk #(.TAG_W(TAG_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .mode_i       (mode_i),
    .adc_oen_o    (adc_oen_o),
    .adc_sel_o    (adc_sel_o),
    .pair_valid_o (pair_valid_o),
    .pair_i_o     (pair_i_o),
    .pair_q_o     (pair_q_o),
    .pair_tag_o   (pair_tag_o)
);

// File: tb/adc_iq_capture_tb_top.sv
`timescale 1ns/1ps
module adc_iq_capture_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       hold = 1'b0;
    logic [9:0] bus = '0;
    logic       oen, sel, vld;
    logic [9:0] pi, pq;
    logic [2:0] tag;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    adc_iq_capture dut_i (
        .clk(clk), .rst(rst), .mode_i(mode), .hold_bus_i(hold),
        .adc_data_i(bus), .adc_oen_o(oen), .adc_sel_o(sel),
        .pair_valid_o(vld), .pair_i_o(pi), .pair_q_o(pq), .pair_tag_o(tag)
    );

    // converter stimulus streams (distinct slopes)
    function automatic logic [9:0] i_of(int n);
        return 10'(((n + 64) * 37 + 5) % 1024);
    endfunction
    function automatic logic [9:0] q_of(int n);
        return 10'(((n + 64) * 91 + 300) % 1024);
    endfunction

    // bench models
    int         edge_n   = 0;
    int         last_evt = 0;
    logic [1:0] mode_m   = 2'b00;
    logic       oen_m    = 1'b0;
    int         tag_m    = 0;

    task automatic check(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at edge %0d: actual %0d expected %0d", req, edge_n, act, exp);
        end
    endtask

    function automatic bit both_edges(logic [1:0] m);
        return (m == 2'b00) || (m == 2'b11);
    endfunction

    task automatic tick();
        bit evt;
        bit vexp;
        int texp;
        @(posedge clk);
        edge_n++;
        evt = rst || (mode != mode_m) || oen_m;
        if (evt) last_evt = edge_n;
        vexp = (edge_n - last_evt) >= 9;
        texp = tag_m;
        if (rst) tag_m = 0;
        else if (vexp) tag_m = (tag_m + 1) % 8;
        mode_m = mode;
        oen_m  = rst ? 1'b0 : hold;
        #3;
        // R4 R5 R6: strobe timing after flush events
        check(vld == vexp, "R4/R5/R6 valid", int'(vld), int'(vexp));
        check(oen == oen_m, "R6 release", int'(oen), int'(oen_m));
        if (rst) begin
            check({pi, pq, tag} == '0, "R9 reset", int'({pi, pq, tag}), 0);
        end
        if (vexp) begin
            check(int'(tag) == texp, "R8 tag", int'(tag), texp);
            if (both_edges(mode_m)) begin
                check(pi == i_of(edge_n - 8), "R1 I", int'(pi), int'(i_of(edge_n - 8)));
                check(pq == q_of(edge_n - 8), "R1 Q", int'(pq), int'(q_of(edge_n - 8)));
            end else if (mode_m == 2'b01) begin
                check(pi == i_of(edge_n - 8), "R2 I", int'(pi), int'(i_of(edge_n - 8)));
                check(pq == 10'd0, "R2 Q zero", int'(pq), 0);
            end else begin
                check(pi == 10'd0, "R3 I zero", int'(pi), 0);
                check(pq == q_of(edge_n - 8), "R3 Q", int'(pq), int'(q_of(edge_n - 8)));
            end
        end
        if (!rst) begin
            if (mode_m == 2'b10) check(sel == 1'b0, "R7 sel Q", int'(sel), 0);
            else                 check(sel == 1'b1, "R7 sel high", int'(sel), 1);
        end
        #2;
        if (oen_m)                 bus = 10'h155;
        else if (mode_m == 2'b01)  bus = i_of(edge_n - 6);
        else                       bus = q_of(edge_n - 7);
        @(negedge clk);
        #3;
        if (!rst && both_edges(mode_m)) check(sel == 1'b0, "R7 sel low phase", int'(sel), 0);
        #2;
        if (both_edges(mode_m) && !oen_m) bus = i_of(edge_n - 6);
        else if (oen_m)                   bus = 10'h2AA;
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    initial begin
        rst = 1'b1; mode = 2'b00;
        run(3);
        rst = 1'b0;
        run(40);                 // R1 interleaved
        mode = 2'b01; run(30);   // R2 I-only
        mode = 2'b10; run(30);   // R3 Q-only
        mode = 2'b00; run(25);
        hold = 1'b1;  run(5);    // R6 released bus
        hold = 1'b0;  run(30);
        mode = 2'b11; run(25);   // R1 alternate interleaved code
        rst = 1'b1;   run(2);    // R9 mid-run reset
        rst = 1'b0;   run(25);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule